// File: doc/BRIEF.md
# Signal Timestamp and Sample Capture Unit

This block turns a vector of monitored signals into a stream of 32-bit words for a downstream buffer controller. The vector carries both external pins and on-chip signals. Every bit first passes through a two-flop synchroniser. A two-bit mode input selects one of three behaviours: off, event timestamping, or grouped sampling.

In event mode, the block watches one selected signal. Each time that signal changes level, in either direction, the block emits the current value of a free-running 32-bit cycle counter. In sampling mode, up to four selected signals form a group. The block captures their values on every pulse of an internal rate divider and packs them into the low bits of a word.

Words leave on a valid/ready interface. A word is transferred on any clock edge where `out_valid` and `out_ready` are both high. While the consumer holds `out_ready` low, the pending word and `out_valid` stay unchanged. Any capture that occurs during such a stall is discarded, because the output stage holds exactly one word. When a transfer and a new capture fall on the same edge, the new word replaces the old one with no idle cycle in between. All control inputs (`mode`, `sel_idx`, `grp_last`, `div_val`) are plain levels and are expected to change only while the mode is off.

Top module: `sig_capture_unit`

## Requirements
- R1: After reset, `out_valid` is low and the timestamp counter is zero. With mode 00 held, no word is ever produced.
- R2: The mode encodings are 00 = off, 01 = event timestamping, 10 = grouped sampling, and 11 = reserved. The reserved code behaves exactly like off and produces no words.
- R3: In event mode, every level change of `sig_in[sel_idx[SW-1:0]]` (lane 0) produces exactly one word. The word holds the counter value of the cycle in which the change becomes visible after two synchroniser flops. If the change is driven while the counter reads C, the word carries C+2.
- R4: The timestamp counter is 32 bits wide, starts at zero when reset is released, and increases by one on every clock. It wraps from all-ones to zero.
- R5: In event mode, a level change on any signal other than the one selected by lane 0 produces no word.
- R6: In sampling mode, the sample pulse fires in the first clock with mode 10 and then once every `div_val`+1 clocks for as long as the mode stays at 10.
- R7: A sampling-mode word carries the synchronised value of `sig_in[sel lane i]` in bit i, for i from 0 to `grp_last`. All other bits, including bits 31..4, are zero. Lane i occupies `sel_idx[i*SW +: SW]`, where SW is the select width (3 at the default of eight signals).
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values. Any capture made during the stall is discarded.
- R9: When a transfer and a new capture occur on the same edge, `out_valid` stays high and `out_data` takes the new word.
- R10: Any index from 0 to NUM_SIG-1 can be selected, whether it refers to a pin or to an on-chip signal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | NUM_SIG | Monitored pins and on-chip signals (asynchronous) |
| mode | input | 2 | 00 off, 01 event, 10 sampling, 11 reserved (off) |
| sel_idx | input | GROUP*clog2(NUM_SIG) | Packed signal index per lane; lane 0 is also the event source |
| grp_last | input | clog2(GROUP) | Index of the highest active lane in sampling mode |
| div_val | input | DIV_W | Sample period minus one, in clocks |
| out_valid | output | 1 | Capture word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 32 | Timestamp or packed sample word |

## Verification
The coinciding case is a transfer on the output and a fresh capture arriving on the same edge. It is provoked by running sampling mode with a divider of zero and `out_ready` held high, so that a word is produced and consumed on every clock. The check is that the word arrival times step by exactly one clock and that each word carries the expected packed group. The opposite case is a capture that arrives during a stall. There the held word must be the first event's timestamp, and exactly one word must emerge once `out_ready` rises.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic [1:0] {
    CAP_OFF    = 2'b00,
    CAP_EVENT  = 2'b01,
    CAP_SAMPLE = 2'b10,
    CAP_RSVD   = 2'b11
  } cap_mode_e;

  localparam int CAP_WORD_W = 32;

endpackage

// File: rtl/cap_sync_bank.sv
module cap_sync_bank #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  // One independent two-stage synchroniser per bit.
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic meta_q;
    logic stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q   <= 1'b0;
        stable_q <= 1'b0;
      end else begin
        meta_q   <= async_in[b];
        stable_q <= meta_q;
      end
    end

    assign sync_out[b] = stable_q;
  end

endmodule

// File: rtl/cap_stamp_counter.sv
module cap_stamp_counter #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] ts
);

  // Free-running; wraps naturally at all-ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts <= '0;
    else        ts <= ts + 1'b1;
  end

endmodule

// File: rtl/cap_rate_divider.sv
module cap_rate_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] period_m1,
  output logic             strobe
);

  logic [DIV_W-1:0] remain_q;

  // A pulse fires whenever the countdown sits at zero; it then reloads.
  assign strobe = run && (remain_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (!run) begin
      remain_q <= '0;
    end else if (remain_q == '0) begin
      remain_q <= period_m1;
    end else begin
      remain_q <= remain_q - 1'b1;
    end
  end

endmodule

// File: rtl/cap_word_builder.sv
module cap_word_builder
  import cap_pkg::*;
#(
  parameter int NUM_SIG = 8,
  parameter int GROUP   = 4,
  parameter int TS_W    = 32,
  parameter int WORD_W  = 32,
  parameter int SEL_W   = (NUM_SIG > 1) ? $clog2(NUM_SIG) : 1,
  parameter int GL_W    = (GROUP > 1) ? $clog2(GROUP) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_SIG-1:0]     sig_sync,
  input  cap_mode_e              mode,
  input  logic [GROUP*SEL_W-1:0] sel_idx,
  input  logic [GL_W-1:0]        grp_last,
  input  logic [TS_W-1:0]        ts,
  input  logic                   samp_strobe,
  output logic                   fire,
  output logic [WORD_W-1:0]      word
);

  logic [NUM_SIG-1:0] sig_prev_q;
  logic [GROUP-1:0]   lane_val;
  logic [GROUP-1:0]   lane_on;
  logic [GROUP-1:0]   lane_bits;
  logic               ev_change;
  logic               is_event;
  logic               is_sample;

  // Previous synchronised level of every signal; tracks continuously so
  // that entering event mode never reports a stale difference.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_prev_q <= '0;
    else        sig_prev_q <= sig_sync;
  end

  // Per-lane selection; out-of-range indices read as zero.
  for (genvar i = 0; i < GROUP; i++) begin : g_lane
    logic [SEL_W-1:0] idx;
    assign idx         = sel_idx[i*SEL_W +: SEL_W];
    assign lane_val[i] = (int'(idx) < NUM_SIG) ? sig_sync[idx] : 1'b0;
    assign lane_on[i]  = (GL_W'(i) <= grp_last);
    assign lane_bits[i] = lane_val[i] & lane_on[i];
  end

  // Event source is lane 0.
  always_comb begin
    logic [SEL_W-1:0] src;
    src = sel_idx[SEL_W-1:0];
    if (int'(src) < NUM_SIG) ev_change = sig_sync[src] ^ sig_prev_q[src];
    else                     ev_change = 1'b0;
  end

  assign is_event  = (mode == CAP_EVENT);
  assign is_sample = (mode == CAP_SAMPLE);

  always_comb begin
    fire = 1'b0;
    word = '0;
    if (is_event) begin
      fire = ev_change;
      word = WORD_W'(ts);
    end else if (is_sample) begin
      fire = samp_strobe;
      word = WORD_W'(lane_bits);
    end
  end

endmodule

// File: rtl/cap_out_stage.sv
module cap_out_stage #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [WORD_W-1:0] word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);

  logic slot_free;

  // The single slot can take a word when empty or when it drains this edge.
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (fire && slot_free) begin
      out_valid <= 1'b1;
      out_data  <= word;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/sig_capture_unit.sv
module sig_capture_unit
  import cap_pkg::*;
#(
  parameter int NUM_SIG = 8,
  parameter int GROUP   = 4,
  parameter int DIV_W   = 16,
  parameter int TS_W    = 32
) (
  input  logic                                                     clk,
  input  logic                                                     rst_n,
  input  logic [NUM_SIG-1:0]                                       sig_in,
  input  logic [1:0]                                               mode,
  input  logic [GROUP*((NUM_SIG > 1) ? $clog2(NUM_SIG) : 1)-1:0]   sel_idx,
  input  logic [((GROUP > 1) ? $clog2(GROUP) : 1)-1:0]             grp_last,
  input  logic [DIV_W-1:0]                                         div_val,
  output logic                                                     out_valid,
  input  logic                                                     out_ready,
  output logic [CAP_WORD_W-1:0]                                    out_data
);

  localparam int SEL_W  = (NUM_SIG > 1) ? $clog2(NUM_SIG) : 1;
  localparam int GL_W   = (GROUP > 1) ? $clog2(GROUP) : 1;
  localparam int WORD_W = CAP_WORD_W;

  cap_mode_e          mode_e;
  logic [NUM_SIG-1:0] sig_sync;
  logic [TS_W-1:0]    ts_now;
  logic               samp_strobe;
  logic               cap_fire;
  logic [WORD_W-1:0]  cap_word;

  assign mode_e = cap_mode_e'(mode);

  cap_sync_bank #(.WIDTH(NUM_SIG)) i_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (sig_in),
    .sync_out (sig_sync)
  );

  cap_stamp_counter #(.TS_W(TS_W)) i_stamp (
    .clk   (clk),
    .rst_n (rst_n),
    .ts    (ts_now)
  );

  cap_rate_divider #(.DIV_W(DIV_W)) i_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (mode_e == CAP_SAMPLE),
    .period_m1 (div_val),
    .strobe    (samp_strobe)
  );

  cap_word_builder #(
    .NUM_SIG (NUM_SIG),
    .GROUP   (GROUP),
    .TS_W    (TS_W),
    .WORD_W  (WORD_W),
    .SEL_W   (SEL_W),
    .GL_W    (GL_W)
  ) i_build (
    .clk         (clk),
    .rst_n       (rst_n),
    .sig_sync    (sig_sync),
    .mode        (mode_e),
    .sel_idx     (sel_idx),
    .grp_last    (grp_last),
    .ts          (ts_now),
    .samp_strobe (samp_strobe),
    .fire        (cap_fire),
    .word        (cap_word)
  );

  cap_out_stage #(.WORD_W(WORD_W)) i_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (cap_fire),
    .word      (cap_word),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

endmodule

// File: rtl/cap_checker.sv
module cap_checker #(
  parameter int GROUP  = 4,
  parameter int DIV_W  = 16,
  parameter int TS_W   = 32,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic [DIV_W-1:0]  div_val,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              strobe,
  input logic [TS_W-1:0]   ts
);

  logic run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= 1'b1;
  end

  // R4: counter advances by exactly one per clock (modulo its width)
  a_r4_ts_step: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> ts == $past(ts) + 1'b1);

  // R8: stalled word and valid are held
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R2: off and reserved modes never raise valid
  a_r2_quiet_modes: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'b00 || mode == 2'b11) && !out_valid) |=> !out_valid);

  // R7: accepted sample words have nothing above the group bits
  a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && (!out_valid || out_ready)) |=>
      (out_valid && out_data[WORD_W-1:GROUP] == '0));

  // R6: with a nonzero divider, pulses never fall on adjacent clocks
  a_r6_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && div_val != '0) |=> !strobe);

  // R9: transfer and capture together leave no bubble
  a_r9_no_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && strobe) |=> out_valid);

endmodule

bind sig_capture_unit cap_checker #(
  .GROUP  (GROUP),
  .DIV_W  (DIV_W),
  .TS_W   (TS_W),
  .WORD_W (WORD_W)
) i_cap_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode),
  .div_val   (div_val),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .strobe    (samp_strobe),
  .ts        (ts_now)
);

// File: tb/test_sig_capture_unit.sv
module test_sig_capture_unit;

  localparam int NS = 8;
  localparam int SW = 3;
  localparam int GR = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NS-1:0]  sig_in = '0;
  logic [1:0]     mode = 2'b00;
  logic [GR*SW-1:0] sel_idx = '0;
  logic [1:0]     grp_last = 2'd0;
  logic [15:0]    div_val = '0;
  logic           out_valid;
  logic           out_ready = 1'b1;
  logic [31:0]    out_data;

  int total = 0;
  int bad   = 0;

  // collector state
  logic [31:0] cnt = '0;
  logic [31:0] got_d [0:511];
  logic [31:0] got_t [0:511];
  int n_got = 0;
  int mark  = 0;

  always #10 clk = ~clk;

  sig_capture_unit i_sig_capture_unit (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .mode(mode),
    .sel_idx(sel_idx), .grp_last(grp_last), .div_val(div_val),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // Records every transfer with the bench's own cycle count (pre-edge).
  always @(posedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready && n_got < 512) begin
        got_d[n_got] = out_data;
        got_t[n_got] = cnt;
        n_got = n_got + 1;
      end
      cnt = cnt + 1;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (5000000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] c0;
    logic [7:0]  pat;
    logic [31:0] expw;
    int          k;
    bit          ok_t;
    bit          ok_d;

    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1: reset state
    check(out_valid == 1'b0, "R1 valid after reset", {31'd0, out_valid}, 0);
    mark = n_got;
    sig_in = 8'hFF;
    tick(8);
    check(n_got - mark == 0, "R1 mode 00 idle", n_got - mark, 0);

    // R2: reserved code behaves as off
    mode = 2'b11;
    sig_in = 8'h00;
    tick(8);
    check(n_got - mark == 0, "R2 mode 11 silent", n_got - mark, 0);
    mode = 2'b00;
    tick(2);

    // R3/R4/R5/R10: event sweep over every index, both edge directions
    mode = 2'b01;
    for (int s = 0; s < NS; s++) begin
      sel_idx = '0;
      sel_idx[SW-1:0] = s[SW-1:0];
      tick(4);
      for (int e = 0; e < 2; e++) begin
        mark = n_got;
        c0 = cnt;
        sig_in[s] = ~sig_in[s];
        tick(6);
        check(n_got - mark == 1, "R3 R10 one word per change", n_got - mark, 1);
        check(got_d[mark] == c0 + 2, "R3 R4 timestamp value", got_d[mark], c0 + 2);
      end
      mark = n_got;
      sig_in[(s + 1) % NS] = ~sig_in[(s + 1) % NS];
      tick(6);
      check(n_got - mark == 0, "R5 unselected change ignored", n_got - mark, 0);
    end

    // R8: stall holds the first word, drops the second
    sel_idx = '0;
    sel_idx[SW-1:0] = 3'd2;
    tick(4);
    out_ready = 1'b0;
    tick(2);
    mark = n_got;
    c0 = cnt;
    sig_in[2] = ~sig_in[2];
    tick(4);
    sig_in[2] = ~sig_in[2];
    tick(8);
    check(out_valid == 1'b1, "R8 valid held", {31'd0, out_valid}, 1);
    check(out_data == c0 + 2, "R8 data held", out_data, c0 + 2);
    out_ready = 1'b1;
    tick(4);
    check(n_got - mark == 1, "R8 stalled capture dropped", n_got - mark, 1);
    check(got_d[mark] == c0 + 2, "R8 delivered word", got_d[mark], c0 + 2);
    mode = 2'b00;
    tick(4);

    // R6/R7/R9: sampling sweep over divider 0..3 and group sizes 1..4
    for (int n = 0; n < 4; n++) begin
      for (int g = 0; g < 4; g++) begin
        pat = 8'hA5 ^ 8'(n * 16 + g * 4 + n);
        sig_in = pat;
        for (int i = 0; i < GR; i++)
          sel_idx[i*SW +: SW] = SW'((i * 3 + n + g) % NS);
        grp_last = 2'(g);
        div_val = 16'(n);
        expw = '0;
        for (int i = 0; i < GR; i++)
          if (i <= g) expw[i] = pat[(i * 3 + n + g) % NS];
        tick(4);
        mark = n_got;
        c0 = cnt;
        mode = 2'b10;
        tick(12);
        mode = 2'b00;
        tick(4);
        k = (12 + n) / (n + 1);
        check(n_got - mark == k, "R6 R9 sample count", n_got - mark, k);
        ok_t = 1'b1;
        ok_d = 1'b1;
        for (int j = 0; j < k; j++) begin
          if (got_t[mark + j] != c0 + 1 + j * (n + 1)) ok_t = 1'b0;
          if (got_d[mark + j] != expw) ok_d = 1'b0;
        end
        check(ok_t, "R6 R9 sample spacing", got_t[mark + 1] - got_t[mark], n + 1);
        check(ok_d, "R7 sample word", got_d[mark], expw);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule